// File: doc/BRIEF.md
# Vector Lane Flag Register Unit

This block keeps the per-lane condition flags of an eight-lane, 16-bit vector unit. An external lane datapath does the arithmetic, compares, clips and merges. This block decides which flag vectors each retiring operation class overwrites with the datapath's per-lane results, which it forces to zero, and which it leaves alone.

There are five 8-bit flag vectors, arranged in three groups:
- A carry group with a low half (per-lane carry or borrow, also used as the sign) and a high half (per-lane equal / not-equal).
- A compare group with a low half (per-lane less-or-equal, compare result or merge select) and a high half (per-lane greater-or-equal).
- One extension vector.

All five vectors are driven continuously to the datapath as its carry, equal, sign and select inputs. A separate move port lets software load any group directly from a 16-bit value, so that flags can be saved and restored.

Updates happen only on a rising clock edge. Within a cycle the outputs always show the state from before that cycle's update.

Top module: `vflag_unit`

## Requirements
- R1: Asserting rst_n low clears all five flag vectors to 0 at once, without waiting for a clock edge.
- R2: With retire_i low and mv_we_i low, no flag vector changes, whatever op_i and the dp_* inputs hold. Op class 0 (logical, multiply, absolute value) and the unused codes 9 to 15 change nothing even when retired.
- R3: Op class 1 (add or subtract with carry in) clears both carry halves. Nothing else changes.
- R4: Op class 2 (add producing carry) loads carry low from dp_carry_i and clears carry high. Nothing else changes.
- R5: Op class 3 (subtract producing borrow) loads carry high from dp_ne_i and carry low from dp_carry_i. Nothing else changes.
- R6: Op class 4 (clip high) loads all five vectors from the datapath:
  - compare high from dp_ge_i and compare low from dp_le_i;
  - carry high from dp_eq_i and carry low from dp_sign_i;
  - extension from dp_ext_i.
- R7: Op classes 5 (clip low) and 6 (clip round) load compare high from dp_ge_i and compare low from dp_le_i. They clear both carry halves and the extension vector.
- R8: Op class 7 (equal, greater-or-equal, less-than, not-equal compares) clears compare high, loads compare low from dp_le_i, and clears both carry halves. The extension vector is kept.
- R9: Op class 8 (merge) clears both carry halves. The compare and extension vectors are kept.
- R10: The move port acts on the clock edge where mv_we_i is high. The mv_sel_i codes are:
  - 0: carry group;
  - 1: compare group;
  - 2: extension vector;
  - 3: no vector.
  For a group, mv_data_i[15:8] goes to the high half and mv_data_i[7:0] to the low half. The extension vector takes mv_data_i[7:0] and ignores the upper byte.
- R11: When a move and a retire share a cycle, the moved vectors take the move value. The other vectors follow the retired op class.
- R12: The outputs in the cycle of a retire or move still show the values from before it. The new values appear after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | Operation retires this cycle |
| op_i | input | 4 | Operation class code |
| dp_carry_i | input | 8 | Datapath per-lane carry / borrow |
| dp_ne_i | input | 8 | Datapath per-lane not-equal |
| dp_ge_i | input | 8 | Datapath per-lane greater-or-equal |
| dp_le_i | input | 8 | Datapath per-lane less-or-equal / compare result |
| dp_eq_i | input | 8 | Datapath per-lane equal |
| dp_sign_i | input | 8 | Datapath per-lane sign |
| dp_ext_i | input | 8 | Datapath extension result |
| mv_we_i | input | 1 | Move port write enable |
| mv_sel_i | input | 2 | Move target select |
| mv_data_i | input | 16 | Move value |
| carry_lo_o | output | 8 | Carry group low half |
| carry_hi_o | output | 8 | Carry group high half |
| cmp_lo_o | output | 8 | Compare group low half |
| cmp_hi_o | output | 8 | Compare group high half |
| ext_o | output | 8 | Extension vector |

## Verification
Every flag vector is first preloaded through the move port with a distinct asymmetric pattern. Each datapath input carries a different value, so a cleared vector, a kept vector and a vector loaded from the wrong datapath input all give different results. Each op class is then retired in turn, including the unused codes and a non-retired cycle carrying a live code.

The extension byte is moved with a non-zero upper byte, which shows that only the low byte is taken. A cycle that moves one group while retiring a class that writes every vector separates the per-vector priority from a whole-block override. An asynchronous reset taken mid-run after non-zero loads shows that reset does not wait for a clock edge.

// File: rtl/vflag_pkg.sv
package vflag_pkg;
  localparam int unsigned NREG = 5;
  // storage slot indices
  localparam int unsigned IX_CLO = 0;
  localparam int unsigned IX_CHI = 1;
  localparam int unsigned IX_KLO = 2;
  localparam int unsigned IX_KHI = 3;
  localparam int unsigned IX_EXT = 4;

  typedef enum logic [3:0] {
    OPC_PASSIVE  = 4'd0,
    OPC_CARRY_IN = 4'd1,
    OPC_ADD_COUT = 4'd2,
    OPC_SUB_BOUT = 4'd3,
    OPC_CLIP_HI  = 4'd4,
    OPC_CLIP_LO  = 4'd5,
    OPC_CLIP_RND = 4'd6,
    OPC_COMPARE  = 4'd7,
    OPC_MERGE    = 4'd8
  } opcls_e;

  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    MV_CARRY = 2'd0,
    MV_CMP   = 2'd1,
    MV_EXT   = 2'd2,
    MV_NONE  = 2'd3
  } mvsel_e;
endpackage

// File: rtl/vflag_op_decode.sv
module vflag_op_decode
  import vflag_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             retire_i,
  input  logic [3:0]       op_i,
  input  logic [LANES-1:0] dp_carry_i,
  input  logic [LANES-1:0] dp_ne_i,
  input  logic [LANES-1:0] dp_ge_i,
  input  logic [LANES-1:0] dp_le_i,
  input  logic [LANES-1:0] dp_eq_i,
  input  logic [LANES-1:0] dp_sign_i,
  input  logic [LANES-1:0] dp_ext_i,
  output act_e             act_o [NREG],
  output logic [LANES-1:0] ld_o  [NREG]
);
  opcls_e opc;
  assign opc = opcls_e'(op_i);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      act_o[i] = ACT_KEEP;
      ld_o[i]  = '0;
    end
    if (retire_i) begin
      case (opc)
        OPC_CARRY_IN, OPC_MERGE: begin
          act_o[IX_CLO] = ACT_CLEAR;
          act_o[IX_CHI] = ACT_CLEAR;
        end
        OPC_ADD_COUT: begin
          act_o[IX_CLO] = ACT_LOAD;
          ld_o[IX_CLO]  = dp_carry_i;
          act_o[IX_CHI] = ACT_CLEAR;
        end
        OPC_SUB_BOUT: begin
          act_o[IX_CLO] = ACT_LOAD;
          ld_o[IX_CLO]  = dp_carry_i;
          act_o[IX_CHI] = ACT_LOAD;
          ld_o[IX_CHI]  = dp_ne_i;
        end
        OPC_CLIP_HI: begin
          act_o[IX_KHI] = ACT_LOAD;
          ld_o[IX_KHI]  = dp_ge_i;
          act_o[IX_KLO] = ACT_LOAD;
          ld_o[IX_KLO]  = dp_le_i;
          act_o[IX_CHI] = ACT_LOAD;
          ld_o[IX_CHI]  = dp_eq_i;
          act_o[IX_CLO] = ACT_LOAD;
          ld_o[IX_CLO]  = dp_sign_i;
          act_o[IX_EXT] = ACT_LOAD;
          ld_o[IX_EXT]  = dp_ext_i;
        end
        OPC_CLIP_LO, OPC_CLIP_RND: begin
          act_o[IX_KHI] = ACT_LOAD;
          ld_o[IX_KHI]  = dp_ge_i;
          act_o[IX_KLO] = ACT_LOAD;
          ld_o[IX_KLO]  = dp_le_i;
          act_o[IX_CHI] = ACT_CLEAR;
          act_o[IX_CLO] = ACT_CLEAR;
          act_o[IX_EXT] = ACT_CLEAR;
        end
        OPC_COMPARE: begin
          act_o[IX_KHI] = ACT_CLEAR;
          act_o[IX_KLO] = ACT_LOAD;
          ld_o[IX_KLO]  = dp_le_i;
          act_o[IX_CHI] = ACT_CLEAR;
          act_o[IX_CLO] = ACT_CLEAR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vflag_move_decode.sv
module vflag_move_decode
  import vflag_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned MVW  = 2 * LANES
) (
  input  logic             mv_we_i,
  input  logic [1:0]       mv_sel_i,
  input  logic [MVW-1:0]   mv_data_i,
  output logic             hit_o [NREG],
  output logic [LANES-1:0] val_o [NREG]
);
  mvsel_e sel;
  assign sel = mvsel_e'(mv_sel_i);

  always_comb begin
    for (int i = 0; i < NREG; i++) hit_o[i] = 1'b0;
    val_o[IX_CLO] = mv_data_i[LANES-1:0];
    val_o[IX_CHI] = mv_data_i[MVW-1:LANES];
    val_o[IX_KLO] = mv_data_i[LANES-1:0];
    val_o[IX_KHI] = mv_data_i[MVW-1:LANES];
    val_o[IX_EXT] = mv_data_i[LANES-1:0];
    if (mv_we_i) begin
      case (sel)
        MV_CARRY: begin
          hit_o[IX_CLO] = 1'b1;
          hit_o[IX_CHI] = 1'b1;
        end
        MV_CMP: begin
          hit_o[IX_KLO] = 1'b1;
          hit_o[IX_KHI] = 1'b1;
        end
        MV_EXT:  hit_o[IX_EXT] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vflag_cell.sv
module vflag_cell
  import vflag_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  act_e         act_i,
  input  logic [W-1:0] ld_i,
  input  logic         mv_hit_i,
  input  logic [W-1:0] mv_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;
  logic         en;

  always_comb begin
    en    = mv_hit_i || (act_i != ACT_KEEP);
    q_nxt = q_r;
    if (mv_hit_i)                q_nxt = mv_val_i;
    else if (act_i == ACT_LOAD)  q_nxt = ld_i;
    else if (act_i == ACT_CLEAR) q_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/vflag_unit.sv
module vflag_unit
  import vflag_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned MVW  = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic [3:0]       op_i,
  input  logic [LANES-1:0] dp_carry_i,
  input  logic [LANES-1:0] dp_ne_i,
  input  logic [LANES-1:0] dp_ge_i,
  input  logic [LANES-1:0] dp_le_i,
  input  logic [LANES-1:0] dp_eq_i,
  input  logic [LANES-1:0] dp_sign_i,
  input  logic [LANES-1:0] dp_ext_i,
  input  logic             mv_we_i,
  input  logic [1:0]       mv_sel_i,
  input  logic [MVW-1:0]   mv_data_i,
  output logic [LANES-1:0] carry_lo_o,
  output logic [LANES-1:0] carry_hi_o,
  output logic [LANES-1:0] cmp_lo_o,
  output logic [LANES-1:0] cmp_hi_o,
  output logic [LANES-1:0] ext_o
);
  act_e             act   [NREG];
  logic [LANES-1:0] ld    [NREG];
  logic             hit   [NREG];
  logic [LANES-1:0] mvv   [NREG];
  logic [LANES-1:0] q     [NREG];

  vflag_op_decode #(.LANES(LANES)) u_dec (
    .retire_i  (retire_i),
    .op_i      (op_i),
    .dp_carry_i(dp_carry_i),
    .dp_ne_i   (dp_ne_i),
    .dp_ge_i   (dp_ge_i),
    .dp_le_i   (dp_le_i),
    .dp_eq_i   (dp_eq_i),
    .dp_sign_i (dp_sign_i),
    .dp_ext_i  (dp_ext_i),
    .act_o     (act),
    .ld_o      (ld)
  );

  vflag_move_decode #(.LANES(LANES)) u_mv (
    .mv_we_i  (mv_we_i),
    .mv_sel_i (mv_sel_i),
    .mv_data_i(mv_data_i),
    .hit_o    (hit),
    .val_o    (mvv)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    vflag_cell #(.W(LANES)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act[g]),
      .ld_i    (ld[g]),
      .mv_hit_i(hit[g]),
      .mv_val_i(mvv[g]),
      .q_o     (q[g])
    );
  end

  assign carry_lo_o = q[IX_CLO];
  assign carry_hi_o = q[IX_CHI];
  assign cmp_lo_o   = q[IX_KLO];
  assign cmp_hi_o   = q[IX_KHI];
  assign ext_o      = q[IX_EXT];
endmodule

// File: rtl/vflag_unit_chk.sv
module vflag_unit_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire_i,
  input logic [3:0]       op_i,
  input logic [LANES-1:0] dp_carry_i,
  input logic [LANES-1:0] dp_ne_i,
  input logic [LANES-1:0] dp_ge_i,
  input logic [LANES-1:0] dp_le_i,
  input logic [LANES-1:0] dp_ext_i,
  input logic             mv_we_i,
  input logic [1:0]       mv_sel_i,
  input logic [2*LANES-1:0] mv_data_i,
  input logic [LANES-1:0] carry_lo_o,
  input logic [LANES-1:0] carry_hi_o,
  input logic [LANES-1:0] cmp_lo_o,
  input logic [LANES-1:0] cmp_hi_o,
  input logic [LANES-1:0] ext_o
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !mv_we_i) |=> ($stable(carry_lo_o) && $stable(carry_hi_o) &&
      $stable(cmp_lo_o) && $stable(cmp_hi_o) && $stable(ext_o)));

  p_cin_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && op_i == 4'd1 && !mv_we_i) |=> (carry_lo_o == '0 && carry_hi_o == '0));

  p_cout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && op_i == 4'd2 && !mv_we_i) |=>
      (carry_lo_o == $past(dp_carry_i) && carry_hi_o == '0));

  p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && op_i == 4'd3 && !mv_we_i) |=>
      (carry_hi_o == $past(dp_ne_i) && carry_lo_o == $past(dp_carry_i)));

  p_cliphi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && op_i == 4'd4 && !mv_we_i) |=>
      (ext_o == $past(dp_ext_i) && cmp_hi_o == $past(dp_ge_i)));

  p_clip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && (op_i == 4'd5 || op_i == 4'd6) && !mv_we_i) |=>
      (ext_o == '0 && carry_lo_o == '0 && cmp_lo_o == $past(dp_le_i)));

  p_compare_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && op_i == 4'd7 && !mv_we_i) |=>
      (cmp_hi_o == '0 && cmp_lo_o == $past(dp_le_i) && $stable(ext_o)));

  p_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_we_i && mv_sel_i == 2'd0) |=> ({carry_hi_o, carry_lo_o} == $past(mv_data_i)));
endmodule

bind vflag_unit vflag_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .op_i(op_i),
  .dp_carry_i(dp_carry_i), .dp_ne_i(dp_ne_i), .dp_ge_i(dp_ge_i),
  .dp_le_i(dp_le_i), .dp_ext_i(dp_ext_i), .mv_we_i(mv_we_i),
  .mv_sel_i(mv_sel_i), .mv_data_i(mv_data_i),
  .carry_lo_o(carry_lo_o), .carry_hi_o(carry_hi_o), .cmp_lo_o(cmp_lo_o),
  .cmp_hi_o(cmp_hi_o), .ext_o(ext_o)
);

// File: tb/tb_vflag_unit.sv
module tb_vflag_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] d_carry = '0, d_ne = '0, d_ge = '0, d_le = '0, d_eq = '0, d_sign = '0, d_ext = '0;
  logic mv_we = 1'b0;
  logic [1:0] mv_sel = '0;
  logic [15:0] mv_data = '0;
  logic [7:0] clo, chi, klo, khi, ext;

  int total = 0;
  int bad = 0;
  logic [39:0] model = '0;  // {ext, khi, klo, chi, clo}

  typedef struct { logic [39:0] v; string req; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  vflag_unit dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .op_i(op),
    .dp_carry_i(d_carry), .dp_ne_i(d_ne), .dp_ge_i(d_ge), .dp_le_i(d_le),
    .dp_eq_i(d_eq), .dp_sign_i(d_sign), .dp_ext_i(d_ext),
    .mv_we_i(mv_we), .mv_sel_i(mv_sel), .mv_data_i(mv_data),
    .carry_lo_o(clo), .carry_hi_o(chi), .cmp_lo_o(klo), .cmp_hi_o(khi), .ext_o(ext)
  );

  function automatic logic [39:0] outs();
    return {ext, khi, klo, chi, clo};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference of the requirements
  function automatic logic [39:0] ref_next(input logic [39:0] s, input logic r, input logic [3:0] o,
      input logic [55:0] dp, input logic w, input logic [1:0] sl, input logic [15:0] md);
    logic [7:0] a0, a1, a2, a3, a4;
    logic [7:0] pc, pn, pg, pl, pe, ps, px;
    {px, ps, pe, pl, pg, pn, pc} = dp;
    {a4, a3, a2, a1, a0} = s;
    if (r) begin
      case (o)
        4'd1, 4'd8: begin a0 = 0; a1 = 0; end
        4'd2: begin a0 = pc; a1 = 0; end
        4'd3: begin a0 = pc; a1 = pn; end
        4'd4: begin a3 = pg; a2 = pl; a1 = pe; a0 = ps; a4 = px; end
        4'd5, 4'd6: begin a3 = pg; a2 = pl; a1 = 0; a0 = 0; a4 = 0; end
        4'd7: begin a3 = 0; a2 = pl; a1 = 0; a0 = 0; end
        default: ;
      endcase
    end
    if (w) begin
      case (sl)
        2'd0: begin a1 = md[15:8]; a0 = md[7:0]; end
        2'd1: begin a3 = md[15:8]; a2 = md[7:0]; end
        2'd2: a4 = md[7:0];
        default: ;
      endcase
    end
    return {a4, a3, a2, a1, a0};
  endfunction

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic go(input logic r, input logic [3:0] o, input logic [55:0] dp,
      input logic w, input logic [1:0] sl, input logic [15:0] md, input string req);
    item_t it;
    @(negedge clk);
    retire = r; op = o; mv_we = w; mv_sel = sl; mv_data = md;
    {d_ext, d_sign, d_eq, d_le, d_ge, d_ne, d_carry} = dp;
    #1;
    check("R12 same-cycle old value", outs(), model);
    it.v = ref_next(model, r, o, dp, w, sl, md);
    it.req = req;
    model = it.v;
    sbq.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(it.req, outs(), it.v);
      end
    end
  end

  localparam logic [55:0] DPA = {8'hE1, 8'hD2, 8'hC3, 8'hB4, 8'hA5, 8'h96, 8'h87};
  localparam logic [55:0] DPB = {8'h1E, 8'h2D, 8'h3C, 8'h4B, 8'h5A, 8'h69, 8'h78};

  task automatic preload();
    go(0, 0, DPA, 1, 2'd0, 16'hA55A, "R10 move carry");
    go(0, 0, DPA, 1, 2'd1, 16'h3CC3, "R10 move compare");
    go(0, 0, DPA, 1, 2'd2, 16'h99F0, "R10 move ext low byte");
  endtask

  initial begin
    #1;
    check("R1 reset state", outs(), 40'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    preload();
    go(0, 0, DPA, 1, 2'd3, 16'hFFFF, "R10 select none");
    go(0, 4'd2, DPA, 0, 0, 0, "R2 no retire");
    go(1, 4'd0, DPA, 0, 0, 0, "R2 passive class");
    for (int c = 9; c < 16; c++) go(1, 4'(c), DPB, 0, 0, 0, "R2 unused code");
    go(1, 4'd1, DPA, 0, 0, 0, "R3 carry-in clear");
    preload();
    go(1, 4'd2, DPA, 0, 0, 0, "R4 add carry out");
    go(1, 4'd3, DPB, 0, 0, 0, "R5 sub borrow out");
    go(1, 4'd4, DPA, 0, 0, 0, "R6 clip high");
    go(1, 4'd5, DPB, 0, 0, 0, "R7 clip low");
    preload();
    go(1, 4'd6, DPA, 0, 0, 0, "R7 clip round");
    preload();
    go(1, 4'd7, DPB, 0, 0, 0, "R8 compare");
    preload();
    go(1, 4'd8, DPA, 0, 0, 0, "R9 merge");
    go(1, 4'd4, DPB, 1, 2'd1, 16'h0FF0, "R11 move beats clip high");
    go(1, 4'd3, DPA, 1, 2'd0, 16'h1234, "R11 move beats borrow");
    go(0, 0, DPA, 0, 0, 0, "R2 idle");
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b0;
    model = '0;
    #1;
    check("R1 async reset mid-run", outs(), 40'h0);
    @(negedge clk);
    rst_n = 1'b1;
    go(1, 4'd2, DPB, 0, 0, 0, "R4 after reset");
    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d expected=0", sbq.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule